// File: doc/BRIEF.md
# Eight-Bit Addressable Latch with Decoder

This block holds eight single-bit storage cells, each driving its own active-high output. A 3-bit address picks one cell, and one serial data bit is steered into it. Bits can therefore be loaded one at a time, in any order, to build a parallel word from a serial stream. Two active-low controls, a write enable and a common clear, choose one of four modes.

- **Write:** the addressed cell takes the data bit and the other cells keep their contents.
- **Hold:** all cells keep their contents. Address and data have no effect.
- **Demultiplex:** the block acts as a 3-to-8 one-hot decoder. The addressed output carries the data bit and all other outputs go low.
- **Clear:** every output goes low, whatever the address and data are.

Storage is built from registers on the rising edge of `clk`. In write and demultiplex modes the data bit appears on the output one cycle after it is sampled. In demultiplex and clear modes the stored bits themselves are overwritten, so the outputs always show the stored state. A following hold therefore keeps the decoded pattern. Callers should change the address only while in hold mode.

Top module: `addr_latch`

## Requirements
- R1: Clear mode (`wen_n`=1, `clr_n`=0) drives all eight `q` bits to 0 at the next rising edge, for every `addr` and `din`.
- R2: Write mode (`wen_n`=0, `clr_n`=1) loads `din` into bit `q[addr]` at the next rising edge.
- R3: In write mode, every bit other than `q[addr]` keeps its previous value.
- R4: Hold mode (`wen_n`=1, `clr_n`=1) keeps all eight bits unchanged, and `addr` and `din` are ignored.
- R5: Demultiplex mode (`wen_n`=0, `clr_n`=0) sets `q[addr]` to `din` and every other bit to 0 at the next rising edge.
- R6: Address value i selects output bit `q[i]`, with `q[0]` the least significant bit. Exactly one cell is selected for any address.
- R7: Outputs change only at a rising edge of `clk`. An input change between edges has no effect until the next edge.
- R8: The pattern left by demultiplex mode is stored, so a following hold keeps it on `q`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for the storage cells |
| din | input | 1 | Serial data bit |
| addr | input | 3 | Cell select, value i picks `q[i]` |
| wen_n | input | 1 | Active-low write enable |
| clr_n | input | 1 | Active-low common clear |
| q | output | 8 | Stored bits, active high |

## Verification
Assertions in every cell check on every cycle what each mode does to that cell at the next edge: load, keep, decode or clear (R1 to R5). The address decoder is checked combinationally for a single selected line (R6). Other properties need sequences of cycles, so only the bench scenarios can show them. These are the mapping of each address to its own output pin, the absence of change between edges, and a decoded pattern persisting through later hold cycles. The bench walks all eight addresses in every mode and compares the full output word against a reference array.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;

   // Mode code is the concatenation {wen_n, clr_n}.
   typedef enum logic [1:0] {
      LM_DEMUX = 2'b00,
      LM_WRITE = 2'b01,
      LM_CLEAR = 2'b10,
      LM_HOLD  = 2'b11
   } latch_mode_e;

   localparam int unsigned MAX_ADDR_W = 6;

endpackage

// File: rtl/latch_mode_dec.sv
module latch_mode_dec
   import addr_latch_pkg::*;
(
   input  logic        wen_n,
   input  logic        clr_n,
   output latch_mode_e mode
);

   always_comb begin
      unique case ({wen_n, clr_n})
         2'b00:   mode = LM_DEMUX;
         2'b01:   mode = LM_WRITE;
         2'b10:   mode = LM_CLEAR;
         default: mode = LM_HOLD;
      endcase
   end

endmodule

// File: rtl/latch_addr_dec.sv
module latch_addr_dec #(
   parameter int unsigned ADDR_W   = 3,
   parameter bit          USE_SHIFT = 1'b0,
   localparam int unsigned N_CELLS = 1 << ADDR_W
) (
   input  logic [ADDR_W-1:0]  addr,
   output logic [N_CELLS-1:0] hit
);

   generate
      if (USE_SHIFT) begin : g_shift
         always_comb hit = N_CELLS'(1) << addr;
      end else begin : g_compare
         for (genvar i = 0; i < N_CELLS; i++) begin : g_line
            assign hit[i] = (addr == ADDR_W'(i));
         end
      end
   endgenerate

   // R6: the decoder selects exactly one cell
   always_comb begin
      assert_one_hit_R6: assert ($countones(hit) == 1 || $isunknown(addr))
         else $error("decoder selected %0d cells", $countones(hit));
   end

endmodule

// File: rtl/latch_bit_cell.sv
module latch_bit_cell
   import addr_latch_pkg::*;
(
   input  logic        clk,
   input  latch_mode_e mode,
   input  logic        hit,
   input  logic        din,
   output logic        q_o
);

   always_ff @(posedge clk) begin
      unique case (mode)
         LM_WRITE: if (hit) q_o <= din;
         LM_DEMUX: q_o <= hit & din;
         LM_CLEAR: q_o <= 1'b0;
         default:  q_o <= q_o;
      endcase
   end

   // Checks become active once a clear has given the cell a known value.
   logic armed = 1'b0;
   always_ff @(posedge clk) if (mode == LM_CLEAR) armed <= 1'b1;

   assert_clear_R1: assert property (@(posedge clk) disable iff (!armed)
      mode == LM_CLEAR |=> q_o == 1'b0);

   assert_write_hit_R2: assert property (@(posedge clk) disable iff (!armed)
      (mode == LM_WRITE && hit) |=> q_o == $past(din));

   assert_write_miss_R3: assert property (@(posedge clk) disable iff (!armed)
      (mode == LM_WRITE && !hit) |=> $stable(q_o));

   assert_hold_R4: assert property (@(posedge clk) disable iff (!armed)
      mode == LM_HOLD |=> $stable(q_o));

   assert_demux_R5: assert property (@(posedge clk) disable iff (!armed)
      mode == LM_DEMUX |=> q_o == ($past(hit) && $past(din)));

endmodule

// File: rtl/addr_latch.sv
module addr_latch
   import addr_latch_pkg::*;
#(
   parameter int unsigned ADDR_W    = 3,
   parameter bit          USE_SHIFT = 1'b0,
   localparam int unsigned N_CELLS  = 1 << ADDR_W
) (
   input  logic               clk,
   input  logic               din,
   input  logic [ADDR_W-1:0]  addr,
   input  logic               wen_n,
   input  logic               clr_n,
   output logic [N_CELLS-1:0] q
);

   generate
      if (ADDR_W < 1 || ADDR_W > MAX_ADDR_W) begin : g_bad_width
         $error("ADDR_W must lie in 1..%0d", MAX_ADDR_W);
      end
   endgenerate

   latch_mode_e               mode;
   logic [N_CELLS-1:0]        hit;

   latch_mode_dec u_mode (
      .wen_n (wen_n),
      .clr_n (clr_n),
      .mode  (mode)
   );

   latch_addr_dec #(
      .ADDR_W    (ADDR_W),
      .USE_SHIFT (USE_SHIFT)
   ) u_dec (
      .addr (addr),
      .hit  (hit)
   );

   generate
      for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
         latch_bit_cell u_cell (
            .clk  (clk),
            .mode (mode),
            .hit  (hit[i]),
            .din  (din),
            .q_o  (q[i])
         );
      end
   endgenerate

endmodule

// File: tb/addr_latch_bench.sv
module addr_latch_bench;

   logic       clk = 1'b0;
   logic       din = 1'b0;
   logic [2:0] addr = '0;
   logic       wen_n = 1'b1;
   logic       clr_n = 1'b0;
   logic [7:0] q;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;
   logic [7:0] ref_q = '0;

   always #10 clk = ~clk;   // 50 MHz

   addr_latch u_addr_latch (
      .clk(clk), .din(din), .addr(addr), .wen_n(wen_n), .clr_n(clr_n), .q(q)
   );

   // Vector layout: {wen_n, clr_n, addr[2:0], din, expected q[7:0]}
   localparam int NV = 12;
   localparam logic [13:0] VEC [NV] = '{
      {1'b1, 1'b0, 3'd0, 1'b1, 8'h00},
      {1'b0, 1'b1, 3'd3, 1'b1, 8'h08},
      {1'b0, 1'b1, 3'd0, 1'b1, 8'h09},
      {1'b0, 1'b1, 3'd7, 1'b1, 8'h89},
      {1'b1, 1'b1, 3'd5, 1'b1, 8'h89},
      {1'b0, 1'b1, 3'd3, 1'b0, 8'h81},
      {1'b0, 1'b0, 3'd2, 1'b1, 8'h04},
      {1'b0, 1'b0, 3'd6, 1'b0, 8'h00},
      {1'b0, 1'b1, 3'd6, 1'b1, 8'h40},
      {1'b1, 1'b0, 3'd6, 1'b1, 8'h00},
      {1'b0, 1'b1, 3'd1, 1'b1, 8'h02},
      {1'b1, 1'b1, 3'd1, 1'b0, 8'h02}
   };

   task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: q=%h expected %h", tag, act, exp);
      end
   endtask

   // Drive one operation, update the reference, compare after the edge.
   task automatic step(input logic w, input logic c, input logic [2:0] a,
                       input logic dv, input string tag);
      @(negedge clk);
      wen_n = w; clr_n = c; addr = a; din = dv;
      case ({w, c})
         2'b01: ref_q[a] = dv;
         2'b00: begin ref_q = '0; ref_q[a] = dv; end
         2'b10: ref_q = '0;
         default: ;
      endcase
      @(negedge clk);
      check(q, ref_q, tag);
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: run did not finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin : main
      // Reset state through clear mode (R1)
      repeat (2) @(negedge clk);
      check(q, 8'h00, "R1 reset state");
      ref_q = '0;

      // Vector table walk
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         {wen_n, clr_n, addr, din} = VEC[i][13:8];
         @(negedge clk);
         check(q, VEC[i][7:0], $sformatf("R2/R3/R4/R5 vector %0d", i));
         ref_q = VEC[i][7:0];
      end

      // R6: each address drives its own output pin
      for (int a = 0; a < 8; a++) begin
         step(1'b1, 1'b0, 3'(a), 1'b1, "R1 clear");
         step(1'b0, 1'b1, 3'(a), 1'b1, "R6 address to pin");
         check(q, 8'h01 << a, "R6 one-hot position");
      end

      // Write walk: R2 addressed bit, R3 others keep
      step(1'b1, 1'b0, 3'd0, 1'b0, "R1 clear");
      for (int a = 0; a < 8; a++) step(1'b0, 1'b1, 3'(a), a[0], "R2 R3 write walk");
      for (int a = 7; a >= 0; a--) step(1'b0, 1'b1, 3'(a), ~ref_q[a], "R2 R3 rewrite walk");

      // Hold walk: R4 addr/din ignored
      for (int a = 0; a < 8; a++) step(1'b1, 1'b1, 3'(a), ~ref_q[a], "R4 hold walk");

      // Demux walk: R5
      for (int a = 0; a < 8; a++) begin
         step(1'b0, 1'b0, 3'(a), 1'b1, "R5 demux high");
         step(1'b0, 1'b0, 3'(a), 1'b0, "R5 demux low");
      end

      // R8: decoded pattern persists in hold
      step(1'b0, 1'b0, 3'd4, 1'b1, "R8 demux load");
      step(1'b1, 1'b1, 3'd1, 1'b1, "R8 hold keeps");
      check(q, 8'h10, "R8 pattern value");

      // Clear walk from all ones: R1
      for (int a = 0; a < 8; a++) begin
         for (int b = 0; b < 8; b++) step(1'b0, 1'b1, 3'(b), 1'b1, "R2 fill");
         step(1'b1, 1'b0, 3'(a), 1'b1, "R1 clear walk");
      end

      // R7: no change between edges
      @(negedge clk);
      wen_n = 1'b0; clr_n = 1'b1; addr = 3'd5; din = 1'b1;
      #5;
      check(q, 8'h00, "R7 no change before edge");
      @(negedge clk);
      ref_q[5] = 1'b1;
      check(q, ref_q, "R7 change after edge");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule